// File: doc/BRIEF.md
# Shared Timer Tick Prescaler with Sampled External Clocks

This block produces the count enables for two timer/counters from one system clock. A free-running 10-bit divider chain yields single-cycle enables at the system clock divided by 8, 64, 256 and 1024. Each timer has its own 3-bit source code. The code picks one of these: no ticks, a tick on every cycle, one of the four divided enables, or a rising or falling edge seen on that timer's own external input pin. Each pin passes through a two-flop synchronizer and an edge register, all clocked by the system clock. A detected pin edge gives exactly one tick and is never divided.

An 8-bit control register sits beside the divider. Writing a one to bit 0 fires a self-clearing strobe. The strobe clears the shared divider, so both timers that draw on a divided enable restart their phase together. Bit 0 and bit 4 always read as zero. The other six bits are plain read/write storage.

Top module: `tpsc_shared_prescaler`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00 and the divider count is 0. The first divide-by-8 tick then falls in the 8th cycle after reset is released.
- R2: Source code 0 gives no ticks. Code 1 gives a tick on every cycle.
- R3: Codes 2, 3, 4 and 5 give a one-cycle tick every 8, 64, 256 and 1024 cycles. The tick comes in the cycle where the divider count modulo that ratio equals the ratio minus one.
- R4: Both timers use the same divider. When both select the same divided code, their ticks are identical in every cycle.
- R5: Writing a value with bit 0 set arms the strobe for the next cycle. In that cycle no divided tick is produced, even when it is a terminal count. The count is 0 in the cycle after that.
- R6: A write with bit 0 clear leaves the divider phase untouched.
- R7: Read data equals the last written value ANDed with 0xEE. Bit 0 (the strobe) and bit 4 (read-only) always read 0.
- R8: Code 7 gives one tick for each rising pin edge. If the pin is first sampled high at clock edge e, the tick is high in the cycle that starts at edge e+1.
- R9: Code 6 gives one tick for each falling pin edge, with the same latency as R8.
- R10: Pin-edge ticks are not divided. The divider strobe does not affect them.
- R11: Each timer's pin drives only that timer's ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data (bit 0 = divider clear strobe) |
| ctl_rdata | output | 8 | Control register read data |
| t0_sel | input | 3 | Timer 0 tick source code |
| t1_sel | input | 3 | Timer 1 tick source code |
| t0_pin | input | 1 | Timer 0 external clock pin (asynchronous) |
| t1_pin | input | 1 | Timer 1 external clock pin (asynchronous) |
| t0_tick | output | 1 | Timer 0 count enable |
| t1_tick | output | 1 | Timer 1 count enable |

## Verification
The bench times a strobe so that its active cycle lands on a divide-by-8 terminal count. A design that let that tick through, or that restarted the count one cycle late, would show a tick where none is expected or miss the next one. Single-cycle pin pulses and pin toggling under repeated strobes show whether an edge detector drops or doubles an edge, or whether pin ticks are wrongly gated by the divider clear. Writes with bit 0 clear and writes of all ones catch a design that clears the divider on any write, or that stores the strobe or read-only bit.

// File: rtl/tpsc_pkg.sv
// Shared constants and the tick-source encoding for the timer prescaler.
// Assumes the four divided taps are ordered from the finest to the coarsest ratio.
package tpsc_pkg;

    localparam int TAP_COUNT  = 4;
    localparam int TAP_LOG2 [TAP_COUNT] = '{3, 6, 8, 10};
    localparam int DIV_W      = TAP_LOG2[TAP_COUNT-1];
    localparam int TAP_IDX_W  = $clog2(TAP_COUNT);
    localparam int SEL_W      = 3;
    localparam int REG_W      = 8;
    localparam int STROBE_BIT = 0;
    localparam int RO_BIT     = 4;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [SEL_W-1:0] {
        CS_OFF      = 3'd0,
        CS_SYS      = 3'd1,
        CS_TAP0     = 3'd2,
        CS_TAP1     = 3'd3,
        CS_TAP2     = 3'd4,
        CS_TAP3     = 3'd5,
        CS_PIN_FALL = 3'd6,
        CS_PIN_RISE = 3'd7
    } clk_sel_e;

endpackage

// File: rtl/tpsc_ctl_reg.sv
// Control register for the prescaler. A write stores the read/write bits and
// arms a one-cycle clear strobe when the strobe bit is one. The strobe bit and
// the read-only bit are never stored, so they always read zero.
// Assumes one write per cycle at most.
module tpsc_ctl_reg
    import tpsc_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int SB_BIT = STROBE_BIT,
    parameter int RO_POS = RO_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         clr_strobe_o
);

    localparam logic [W-1:0] RW_MASK = ~((W'(1) << SB_BIT) | (W'(1) << RO_POS));

    logic [W-1:0] store_q;
    logic         strobe_q;

    // Keep the plain storage bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       store_q <= '0;
        else if (wr_en_i) store_q <= wdata_i & RW_MASK;
    end

    // Arm the clear strobe for exactly one cycle after a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= wr_en_i & wdata_i[SB_BIT];
    end

    assign rdata_o      = store_q & RW_MASK;
    assign clr_strobe_o = strobe_q;

endmodule

// File: rtl/tpsc_divider.sv
// Free-running divider chain shared by both timers. Each tap is a single-cycle
// enable raised when the low TAP_LOG2[g] bits of the count are all ones.
// A clear cycle suppresses every tap and the count is zero on the next cycle.
module tpsc_divider
    import tpsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    output logic [TAP_COUNT-1:0] tap_en_o
);

    logic [DIV_W-1:0] cnt_q;

    // Advance the count, or restart it on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < TAP_COUNT; g++) begin : g_tap
        localparam int L = TAP_LOG2[g];
        assign tap_en_o[g] = !clr_i && (&cnt_q[L-1:0]);
    end

endmodule

// File: rtl/tpsc_pin_edge.sv
// Synchronizes one asynchronous pin into the system clock and flags its edges.
// Assumes each pin phase lasts longer than one system clock period.
// The edge flags are one cycle wide and follow the pin by DEPTH cycles.
module tpsc_pin_edge
    import tpsc_pkg::*;
#(
    parameter int DEPTH = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [DEPTH-1:0] sync_q;
    logic             last_q;
    logic             level;

    assign level = sync_q[DEPTH-1];

    // Move the pin through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[DEPTH-2:0], pin_i};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= level;
    end

    assign rise_o = level & ~last_q;
    assign fall_o = ~level & last_q;

endmodule

// File: rtl/tpsc_tick_mux.sv
// Chooses one timer's tick from the shared taps, the system tick or its own
// pin edges according to the 3-bit source code.
module tpsc_tick_mux
    import tpsc_pkg::*;
(
    input  clk_sel_e             sel_i,
    input  logic [TAP_COUNT-1:0] tap_en_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    output logic                 tick_o
);

    logic [TAP_IDX_W-1:0] tap_idx;

    // Decode the source code into a single tick enable.
    always_comb begin
        tap_idx = TAP_IDX_W'(sel_i - CS_TAP0);
        case (sel_i)
            CS_OFF:      tick_o = 1'b0;
            CS_SYS:      tick_o = 1'b1;
            CS_PIN_FALL: tick_o = fall_i;
            CS_PIN_RISE: tick_o = rise_i;
            default:     tick_o = tap_en_i[tap_idx];
        endcase
    end

endmodule

// File: rtl/tpsc_shared_prescaler.sv
// Top of the shared prescaler: one control register, one divider chain and,
// per timer, a pin edge detector and a tick source multiplexer.
// Assumes the pins are asynchronous and slower than half the system clock.
module tpsc_shared_prescaler
    import tpsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic [SEL_W-1:0] t0_sel,
    input  logic [SEL_W-1:0] t1_sel,
    input  logic             t0_pin,
    input  logic             t1_pin,
    output logic             t0_tick,
    output logic             t1_tick
);

    localparam int N_TMR = 2;

    logic                 div_clr;
    logic [TAP_COUNT-1:0] tap_en;
    logic [N_TMR-1:0]     pins;
    logic [N_TMR-1:0]     ticks;
    clk_sel_e             sels [N_TMR];

    assign pins    = {t1_pin, t0_pin};
    assign sels[0] = clk_sel_e'(t0_sel);
    assign sels[1] = clk_sel_e'(t1_sel);

    tpsc_ctl_reg u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (ctl_wr_en),
        .wdata_i      (ctl_wdata),
        .rdata_o      (ctl_rdata),
        .clr_strobe_o (div_clr)
    );

    tpsc_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (div_clr),
        .tap_en_o (tap_en)
    );

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        logic rise, fall;

        tpsc_pin_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[t]),
            .rise_o (rise),
            .fall_o (fall)
        );

        tpsc_tick_mux u_mux (
            .sel_i    (sels[t]),
            .tap_en_i (tap_en),
            .rise_i   (rise),
            .fall_i   (fall),
            .tick_o   (ticks[t])
        );
    end

    assign t0_tick = ticks[0];
    assign t1_tick = ticks[1];

endmodule

// File: rtl/tpsc_checker.sv
// Port-level properties of the shared prescaler, bound to its top module.
module tpsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr_en,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic [2:0] t0_sel,
    input logic [2:0] t1_sel,
    input logic       t0_tick,
    input logic       t1_tick
);

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_sel == 3'd0) |-> !t0_tick);

    a_r2_sys_every: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_sel == 3'd1) |-> t1_tick);

    a_r4_taps_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_sel == t1_sel && t0_sel >= 3'd2 && t0_sel <= 3'd5) |-> (t0_tick == t1_tick));

    a_r5_clear_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_wr_en) && $past(ctl_wdata[0])
         && t0_sel >= 3'd2 && t0_sel <= 3'd5) |-> !t0_tick);

    a_r7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] && !ctl_rdata[4]);

    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_sel == 3'd7 && t0_tick) |=> !(t0_sel == 3'd7 && t0_tick));

endmodule

bind tpsc_shared_prescaler tpsc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr_en (ctl_wr_en),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .t0_sel    (t0_sel),
    .t1_sel    (t1_sel),
    .t0_tick   (t0_tick),
    .t1_tick   (t1_tick)
);

// File: tb/tb_tpsc_shared_prescaler.sv
`timescale 1ns/1ps
module tb_tpsc_shared_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic [2:0] t0_sel = '0, t1_sel = '0;
    logic       t0_pin = 1'b0, t1_pin = 1'b0;
    logic       t0_tick, t1_tick;

    always #2.5 clk = ~clk;

    tpsc_shared_prescaler dut (.*);

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;
    string dir_tag = "";

    // Model state for the cycle about to be checked.
    int         m_cnt = 0;
    logic       m_strb = 0;
    logic [7:0] m_reg = '0;
    logic [2:0] m_pa = '0, m_pb = '0;   // {edge reg, sync2, sync1} per timer

    // Next-cycle input values.
    logic       b_rst = 0, b_wr = 0, b_p0 = 0, b_p1 = 0;
    logic [7:0] b_wd = '0;
    logic [2:0] b_s0 = '0, b_s1 = '0;

    function automatic logic exp_tick(logic [2:0] sel, int cnt, logic strb, logic [2:0] ph);
        case (sel)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return !strb && (cnt % 8 == 7);
            3'd3: return !strb && (cnt % 64 == 63);
            3'd4: return !strb && (cnt % 256 == 255);
            3'd5: return !strb && (cnt % 1024 == 1023);
            3'd6: return !ph[1] && ph[2];
            default: return ph[1] && !ph[2];
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] sel, logic strb);
        if (dir_tag != "") return dir_tag;
        if (sel <= 3'd1) return "R2";
        if (sel <= 3'd5) return strb ? "R5" : "R3";
        return (sel == 3'd6) ? "R9" : "R8";
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: check outputs, drive next inputs, advance the model.
    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk(tag_of(t0_sel, m_strb), "t0_tick", 8'(t0_tick), 8'(exp_tick(t0_sel, m_cnt, m_strb, m_pa)));
            chk(tag_of(t1_sel, m_strb), "t1_tick", 8'(t1_tick), 8'(exp_tick(t1_sel, m_cnt, m_strb, m_pb)));
            chk(dir_tag != "" ? dir_tag : "R7", "rdata", ctl_rdata, m_reg);
            if (t0_sel == t1_sel && t0_sel >= 3'd2 && t0_sel <= 3'd5)
                chk("R4", "t0_vs_t1", 8'(t0_tick), 8'(t1_tick));
        end
        rst_n = !b_rst; ctl_wr_en = b_wr; ctl_wdata = b_wd;
        t0_sel = b_s0; t1_sel = b_s1; t0_pin = b_p0; t1_pin = b_p1;
        if (b_rst) begin
            m_cnt = 0; m_strb = 0; m_reg = '0; m_pa = '0; m_pb = '0;
        end else begin
            m_cnt  = m_strb ? 0 : (m_cnt + 1) % 1024;
            m_strb = b_wr && b_wd[0];
            if (b_wr) m_reg = b_wd & 8'hEE;
            m_pa = {m_pa[1:0], b_p0};
            m_pb = {m_pb[1:0], b_p1};
        end
    endtask

    task automatic wr(logic [7:0] d);
        b_wr = 1; b_wd = d; cyc(); b_wr = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        b_rst = 1; run(3);
        b_rst = 0; dir_tag = "R1"; cyc();
        chk("R1", "rdata_after_reset", ctl_rdata, 8'h00);
        b_s0 = 3'd2; run(8); dir_tag = "";
        // R3: all taps across a full divider period
        b_s0 = 3'd2; b_s1 = 3'd3; run(1100);
        b_s0 = 3'd4; b_s1 = 3'd5; run(2100);
        // R2: off and every-cycle
        b_s0 = 3'd0; b_s1 = 3'd1; run(20);
        // R4: shared tap
        dir_tag = "R4"; b_s0 = 3'd3; b_s1 = 3'd3; run(200); dir_tag = "";
        // R5: strobe lands on a divide-by-8 terminal count
        b_s0 = 3'd2; b_s1 = 3'd2;
        while (m_cnt != 6) cyc();
        dir_tag = "R5"; wr(8'h01); run(20); dir_tag = "";
        // R6: write with bit 0 clear keeps the phase
        dir_tag = "R6"; wr(8'hFE); run(30); wr(8'h00); run(30); dir_tag = "";
        // R7: masked readback
        dir_tag = "R7"; wr(8'hFF); cyc(); chk("R7", "rdata_ff", ctl_rdata, 8'hEE);
        wr(8'h11); cyc(); chk("R7", "rdata_11", ctl_rdata, 8'h00); dir_tag = "";
        // R8 / R9: short and long pin pulses
        b_s0 = 3'd7; b_s1 = 3'd6;
        for (int w = 1; w <= 4; w++) begin
            b_p0 = 1; b_p1 = 1; run(w);
            b_p0 = 0; b_p1 = 0; run(w + 1);
        end
        run(4);
        // R10: pin ticks through repeated strobes
        dir_tag = "R10";
        for (int k = 0; k < 40; k++) begin
            b_p0 = ~b_p0; b_p1 = ~b_p1;
            if (k % 3 == 0) wr(8'h01); else cyc();
            cyc();
        end
        dir_tag = ""; run(4);
        // R11: only timer 0's pin moves
        dir_tag = "R11"; b_s0 = 3'd7; b_s1 = 3'd7; b_p1 = 0; run(4);
        for (int k = 0; k < 20; k++) begin b_p0 = ~b_p0; run(2); end
        dir_tag = ""; run(4);
        // Constrained random mix
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(39) == 0) b_s0 = 3'($urandom_range(7));
            if ($urandom_range(39) == 0) b_s1 = 3'($urandom_range(7));
            if ($urandom_range(2) == 0) b_p0 = ~b_p0;
            if ($urandom_range(2) == 0) b_p1 = ~b_p1;
            if ($urandom_range(49) == 0) wr(8'($urandom_range(255)));
            else cyc();
        end
        // Mid-run reset
        b_s0 = 3'd0; b_s1 = 3'd0; b_rst = 1; run(2); b_rst = 0;
        dir_tag = "R1"; cyc(); chk("R1", "rdata_rereset", ctl_rdata, 8'h00);
        b_s0 = 3'd2; run(20); dir_tag = "";
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule